// File: doc/BRIEF.md
# Modem Handshake and Control-Channel Logic

This block drives the three modem-side control lines of a point-to-point serial modem: carrier detect, clear to send and data set ready, all active low. It also drives an active-high lock indicator. A mode-select input chooses what the control lines carry.

In data-channel mode, the request-to-send and terminal-ready inputs are treated as two slow data channels. A divider samples them once per sampling period, and the sampled levels appear on clear-to-send and data-set-ready. This happens whatever loopback is active. In handshake mode, the lines follow the usual terminal/modem request-and-answer rules. These rules combine link lock, terminal-ready, request-to-send and the current loopback mode.

The lock indicator is a registered copy of link lock. No handshake input, mode select or loopback setting affects it. Every input is asynchronous and passes through a synchronizer, and every output comes from a flop.

Top module: `hsk_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `carrier_n`, `clr_send_n` and `set_rdy_n` are high and `lock_ind` is low.
- R2: With `hsk_sel` low (data-channel mode), `clr_send_n` and `set_rdy_n` take the levels of `rts_in_n` and `dtr_in_n`. Both are sampled together once every `SAMPLE_DIV` clocks (1536 by default), and between samples both outputs hold.
- R3: With `hsk_sel` high, `carrier_n` is low only when link lock is high, `dtr_in_n` is low and `loop_mode` is 2'b00 or 2'b10. When lock is lost, `carrier_n` and `clr_send_n` both go high.
- R4: With `hsk_sel` high and `dtr_in_n` high, `carrier_n` and `clr_send_n` are high.
- R5: With `hsk_sel` high, `clr_send_n` is low exactly when all four of these hold: `rts_in_n` is low, lock is high, `dtr_in_n` is low and `loop_mode` is not 2'b11. It returns high when `rts_in_n` goes high.
- R6: With `hsk_sel` high and reset released, `set_rdy_n` is low.
- R7: The `loop_mode` encoding is as follows:
  - 2'b00: no loopback.
  - 2'b01: local loopback, which forces `carrier_n` high.
  - 2'b10: remote loopback at the initiating end, which leaves `carrier_n` low when the other conditions hold.
  - 2'b11: remote loopback at the far end, which forces both `carrier_n` and `clr_send_n` high.
- R8: In data-channel mode, an active loopback does not stop the sampled levels from reaching `clr_send_n` and `set_rdy_n`. In this mode `carrier_n` depends on lock and `loop_mode` only, not on `dtr_in_n`.
- R9: `lock_ind` is high exactly when link lock is high, and is independent of `rts_in_n`, `dtr_in_n`, `hsk_sel` and `loop_mode`. In handshake mode, with `dtr_in_n` low and `loop_mode` 2'b00, it equals the inverse of `carrier_n`.
- R10: With the default `SYNC_STAGES` of 2, an input change made between clock edges reaches `lock_ind` and the handshake-mode outputs at the third rising edge. At the second edge these outputs still show the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsk_sel | input | 1 | Mode select: 1 = handshake mode, 0 = data-channel mode |
| rts_in_n | input | 1 | Request to send from the terminal, or data channel A |
| dtr_in_n | input | 1 | Terminal ready, or data channel B |
| link_lock | input | 1 | Link synchronisation achieved, active high |
| loop_mode | input | 2 | Loopback mode: 00 none, 01 local, 10 remote initiator, 11 remote far end |
| carrier_n | output | 1 | Carrier detect, active low |
| clr_send_n | output | 1 | Clear to send, or data channel A output |
| set_rdy_n | output | 1 | Data set ready, or data channel B output |
| lock_ind | output | 1 | Raw lock indicator, active high |

## Verification
The assertions assume that each input holds long enough for the synchronizer to see every level. They also assume that both bits of `loop_mode` change at the same moment, so no transient third code passes through the synchronizer. The stimulus changes inputs only on falling clock edges and changes the two loop bits in one assignment. It holds each setting for several clocks before sampling. In data-channel mode it first finds the sampling phase from an output edge, then times later checks from that edge.

// File: rtl/hsk_pkg.sv
`timescale 1ns/1ps
package hsk_pkg;
   typedef enum logic [1:0] {
      LOOP_NONE     = 2'b00,
      LOOP_LOCAL    = 2'b01,
      LOOP_RMT_INIT = 2'b10,
      LOOP_RMT_FAR  = 2'b11
   } loop_e;
endpackage

// File: rtl/hsk_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a group of independent asynchronous bits.
module hsk_sync #(
   parameter int W = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hsk_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("hsk_sync: W must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hsk_tick.sv
`timescale 1ns/1ps
// Free-running divider: one-cycle tick every DIV clocks.
module hsk_tick #(
   parameter int DIV = 1536
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   if (DIV < 4) begin : g_bad_div
      $error("hsk_tick: DIV must be at least 4");
   end

   localparam int CW = $clog2(DIV);
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);
   localparam bit POW2 = (DIV == (1 << CW));

   logic [CW-1:0] cnt;

   if (POW2) begin : g_wrap
      // Power-of-two period: the counter wraps on its own.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cnt <= '0;
         else        cnt <= cnt + 1'b1;
      end
   end else begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           cnt <= '0;
         else if (cnt == LAST) cnt <= '0;
         else                  cnt <= cnt + 1'b1;
      end
   end

   assign tick = (cnt == LAST);
endmodule

// File: rtl/hsk_rules.sv
`timescale 1ns/1ps
// Handshake decision logic (purely combinational).
module hsk_rules
   import hsk_pkg::*;
(
   input  logic  hsk_mode,
   input  logic  lock,
   input  logic  dtr_act,
   input  logic  rts_act,
   input  loop_e loop,
   output logic  carrier_act,
   output logic  cts_act
);
   logic loop_pass;
   logic dtr_ok;

   always_comb begin
      loop_pass   = (loop == LOOP_NONE) || (loop == LOOP_RMT_INIT);
      dtr_ok      = !hsk_mode || dtr_act;
      carrier_act = lock && dtr_ok && loop_pass;
      cts_act     = hsk_mode && rts_act && lock && dtr_act && (loop != LOOP_RMT_FAR);
   end
endmodule

// File: rtl/hsk_ctrl.sv
`timescale 1ns/1ps
module hsk_ctrl
   import hsk_pkg::*;
#(
   parameter int SAMPLE_DIV  = 1536,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hsk_sel,
   input  logic       rts_in_n,
   input  logic       dtr_in_n,
   input  logic       link_lock,
   input  logic [1:0] loop_mode,
   output logic       carrier_n,
   output logic       clr_send_n,
   output logic       set_rdy_n,
   output logic       lock_ind
);
   localparam int NIN = 6;
   // Bit order: sel, rts, dtr, lock, loop[1:0]; handshake lines reset inactive.
   localparam logic [NIN-1:0] IN_RST = 6'b011000;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("hsk_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [NIN-1:0] raw_in, syn_in;
   logic  sel_s, rts_s, dtr_s, lock_s;
   loop_e loop_s;
   logic  tick;
   logic  carrier_act, cts_act;

   assign raw_in = {hsk_sel, rts_in_n, dtr_in_n, link_lock, loop_mode};

   hsk_sync #(.W(NIN), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
   );

   assign sel_s  = syn_in[5];
   assign rts_s  = syn_in[4];
   assign dtr_s  = syn_in[3];
   assign lock_s = syn_in[2];
   assign loop_s = loop_e'(syn_in[1:0]);

   hsk_tick #(.DIV(SAMPLE_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   hsk_rules u_rules (
      .hsk_mode(sel_s), .lock(lock_s), .dtr_act(!dtr_s), .rts_act(!rts_s),
      .loop(loop_s), .carrier_act(carrier_act), .cts_act(cts_act)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         carrier_n  <= 1'b1;
         clr_send_n <= 1'b1;
         set_rdy_n  <= 1'b1;
         lock_ind   <= 1'b0;
      end else begin
         lock_ind  <= lock_s;
         carrier_n <= !carrier_act;
         if (sel_s) begin
            clr_send_n <= !cts_act;
            set_rdy_n  <= 1'b0;
         end else if (tick) begin
            clr_send_n <= rts_s;
            set_rdy_n  <= dtr_s;
         end
      end
   end
endmodule

// File: rtl/hsk_ctrl_chk.sv
`timescale 1ns/1ps
module hsk_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sel_s,
   input logic       rts_s,
   input logic       dtr_s,
   input logic       lock_s,
   input logic [1:0] loop_s,
   input logic       tick,
   input logic       carrier_n,
   input logic       clr_send_n,
   input logic       set_rdy_n,
   input logic       lock_ind
);
   assert_data_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_s && tick) |=> (clr_send_n == $past(rts_s)) && (set_rdy_n == $past(dtr_s)));

   assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_s && !tick) |=> $stable(clr_send_n) && $stable(set_rdy_n));

   assert_no_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_s |=> carrier_n && (!sel_s || clr_send_n));

   assert_dtr_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_s && dtr_s) |=> carrier_n && clr_send_n);

   assert_rts_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_s && rts_s) |=> clr_send_n);

   assert_dsr_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sel_s |=> !set_rdy_n);

   assert_loop_dcd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_s == 2'b01 || loop_s == 2'b11) |=> carrier_n);

   assert_far_cts_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_s && loop_s == 2'b11) |=> clr_send_n);

   assert_lock_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lock_s |=> lock_ind);

   assert_lock_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_s |=> !lock_ind);
endmodule

bind hsk_ctrl hsk_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .rts_s(rts_s), .dtr_s(dtr_s),
   .lock_s(lock_s), .loop_s(loop_s), .tick(tick), .carrier_n(carrier_n),
   .clr_send_n(clr_send_n), .set_rdy_n(set_rdy_n), .lock_ind(lock_ind)
);

// File: tb/hsk_ctrl_tb.sv
`timescale 1ns/1ps
module hsk_ctrl_tb;
   localparam int DIV = 1536;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hsk_sel = 1'b0;
   logic       rts_in_n = 1'b1;
   logic       dtr_in_n = 1'b1;
   logic       link_lock = 1'b0;
   logic [1:0] loop_mode = 2'b00;
   logic       carrier_n, clr_send_n, set_rdy_n, lock_ind;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   hsk_ctrl #(.SAMPLE_DIV(DIV), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .hsk_sel(hsk_sel), .rts_in_n(rts_in_n),
      .dtr_in_n(dtr_in_n), .link_lock(link_lock), .loop_mode(loop_mode),
      .carrier_n(carrier_n), .clr_send_n(clr_send_n), .set_rdy_n(set_rdy_n),
      .lock_ind(lock_ind)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic t_reset();
      #2;
      chk("R1", "carrier_n in reset", carrier_n, 1'b1);
      chk("R1", "clr_send_n in reset", clr_send_n, 1'b1);
      chk("R1", "set_rdy_n in reset", set_rdy_n, 1'b1);
      chk("R1", "lock_ind in reset", lock_ind, 1'b0);
      step(3);
      rst_n = 1'b1;
      step(1);
      chk("R1", "carrier_n after reset", carrier_n, 1'b1);
      chk("R1", "clr_send_n after reset", clr_send_n, 1'b1);
      chk("R1", "set_rdy_n after reset", set_rdy_n, 1'b1);
      chk("R1", "lock_ind after reset", lock_ind, 1'b0);
   endtask

   // R2: periodic sampling in data-channel mode.
   task automatic t_data_sample();
      bit seen = 1'b0;
      rts_in_n = 1'b0;
      for (int i = 0; i < DIV + 8; i++) begin
         step(1);
         if (clr_send_n == 1'b0) begin
            seen = 1'b1;
            break;
         end
      end
      chk("R2", "sampled channel A reached output", seen, 1'b1);
      chk("R2", "channel B still high", set_rdy_n, 1'b1);
      rts_in_n = 1'b1;
      dtr_in_n = 1'b0;
      step(DIV - 10);
      chk("R2", "channel A held between samples", clr_send_n, 1'b0);
      chk("R2", "channel B held between samples", set_rdy_n, 1'b1);
      step(14);
      chk("R2", "channel A updated at next sample", clr_send_n, 1'b1);
      chk("R2", "channel B updated at next sample", set_rdy_n, 1'b0);
   endtask

   // R8: loopback in data-channel mode.
   task automatic t_data_loop();
      link_lock = 1'b1;
      loop_mode = 2'b01;
      rts_in_n = 1'b0;
      dtr_in_n = 1'b1;
      step(DIV + 6);
      chk("R8", "channel A passes in local loop", clr_send_n, 1'b0);
      chk("R8", "channel B passes in local loop", set_rdy_n, 1'b1);
      chk("R8", "carrier off in local loop", carrier_n, 1'b1);
      loop_mode = 2'b10;
      step(5);
      chk("R8", "carrier ignores dtr in data mode", carrier_n, 1'b0);
   endtask

   task automatic t_hsk_basic();
      hsk_sel = 1'b1;
      loop_mode = 2'b00;
      dtr_in_n = 1'b0;
      rts_in_n = 1'b1;
      step(5);
      chk("R3", "carrier on when locked", carrier_n, 1'b0);
      chk("R6", "dsr on in handshake mode", set_rdy_n, 1'b0);
      chk("R5", "cts off with rts idle", clr_send_n, 1'b1);
      chk("R9", "lock_ind inverse of carrier", lock_ind, ~carrier_n);
      rts_in_n = 1'b0;
      step(2);
      chk("R10", "cts not yet at second edge", clr_send_n, 1'b1);
      step(1);
      chk("R10", "cts at third edge", clr_send_n, 1'b0);
      chk("R5", "cts on with rts active", clr_send_n, 1'b0);
      rts_in_n = 1'b1;
      step(4);
      chk("R5", "cts off after rts released", clr_send_n, 1'b1);
   endtask

   task automatic t_dtr();
      rts_in_n = 1'b0;
      dtr_in_n = 1'b1;
      step(4);
      chk("R4", "carrier off with dtr idle", carrier_n, 1'b1);
      chk("R4", "cts off with dtr idle", clr_send_n, 1'b1);
      chk("R6", "dsr stays on with dtr idle", set_rdy_n, 1'b0);
      chk("R9", "lock_ind ignores dtr", lock_ind, 1'b1);
      dtr_in_n = 1'b0;
      step(4);
      chk("R4", "carrier back with dtr active", carrier_n, 1'b0);
      chk("R5", "cts back with dtr active", clr_send_n, 1'b0);
   endtask

   task automatic t_lock_loss();
      link_lock = 1'b0;
      step(4);
      chk("R3", "carrier off on lock loss", carrier_n, 1'b1);
      chk("R3", "cts off on lock loss", clr_send_n, 1'b1);
      chk("R9", "lock_ind low on lock loss", lock_ind, 1'b0);
      link_lock = 1'b1;
      step(4);
      chk("R3", "carrier on after relock", carrier_n, 1'b0);
      chk("R3", "cts on after relock", clr_send_n, 1'b0);
   endtask

   task automatic t_loop();
      loop_mode = 2'b01;
      step(4);
      chk("R7", "carrier off in local loop", carrier_n, 1'b1);
      chk("R7", "cts kept in local loop", clr_send_n, 1'b0);
      chk("R9", "lock_ind ignores loop", lock_ind, 1'b1);
      loop_mode = 2'b10;
      step(4);
      chk("R7", "carrier on at remote initiator", carrier_n, 1'b0);
      chk("R7", "cts on at remote initiator", clr_send_n, 1'b0);
      loop_mode = 2'b11;
      step(4);
      chk("R7", "carrier off at remote far end", carrier_n, 1'b1);
      chk("R7", "cts off at remote far end", clr_send_n, 1'b1);
      chk("R9", "lock_ind at remote far end", lock_ind, 1'b1);
      loop_mode = 2'b00;
      step(4);
   endtask

   task automatic t_lock_ind();
      hsk_sel = 1'b0;
      rts_in_n = 1'b1;
      dtr_in_n = 1'b1;
      loop_mode = 2'b11;
      step(4);
      chk("R9", "lock_ind high in data mode with loop", lock_ind, 1'b1);
      link_lock = 1'b0;
      step(2);
      chk("R10", "lock_ind not yet at second edge", lock_ind, 1'b1);
      step(1);
      chk("R10", "lock_ind falls at third edge", lock_ind, 1'b0);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_data_sample();
      t_data_loop();
      t_hsk_basic();
      t_dtr();
      t_lock_loss();
      t_loop();
      t_lock_ind();
      done = 1'b1;
      summary();
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         summary();
      end
   end
endmodule